// File: doc/BRIEF.md
# Pseudo-SRAM Power-Up and Deep-Sleep Sequencer

This block drives the power-control chip enable of an asynchronous pseudo-SRAM and decides when the memory's access controller may use the bus. After the supply-good input goes high it holds the memory in the power-up state for the required intervals. During this time it also forces the primary chip enable high. Only after that does it grant the bus. A parameter selects one of two power-up orderings. The default path holds the power-control enable low first and then waits through a long recovery. The alternate path raises the power-control enable at once and runs one full deep-sleep entry and exit before the same recovery.

During operation the host may ask for deep sleep. The request waits in the sequencer until the access controller reports idle. The sequencer then withdraws the grant and forces the primary enable high for a setup interval. Next it drops the power-control enable and keeps it low for at least the minimum time. It raises the enable again on a wake request, then holds the primary enable high for an exit interval and the full recovery time before granting the bus again. A wake request that arrives while the entry timing is still running is remembered and acted on when the minimum low time has passed. The memory's data pins float throughout, because no access can start without the grant.

All intervals are parameters counted in clock cycles. The defaults assume a 100 MHz clock. Each interval must be at least one cycle.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it is released with supply_ok low, bus_grant is 0, ce2 is 0, ce1_force_hi is 1 and busy is 1.
- R2: With ALT_POWERUP = 0, once supply_ok is high ce2 stays low for PU_HOLD_CYC cycles. It is then high with ce1_force_hi = 1 and bus_grant = 0 for exactly RECOVER_CYC cycles before bus_grant rises.
- R3: With ALT_POWERUP = 1, ce2 rises one cycle after supply_ok while ce1_force_hi is already 1, and stays high for PU_HOLD_CYC + CE1_SETUP_CYC cycles. It is then low for exactly PD_MIN_CYC cycles, and is high for EXIT_HOLD_CYC + RECOVER_CYC cycles before bus_grant rises. No wake request is needed.
- R4: A sleep request seen while the bus is granted is held until ctrl_idle is 1. bus_grant falls only in the cycle after one where ctrl_idle was 1.
- R5: ce1_force_hi is 1 for at least CE1_SETUP_CYC cycles before every fall of ce2 that is not caused by a loss of supply.
- R6: ce2 stays low for at least PD_MIN_CYC cycles after each deep-sleep entry.
- R7: Without a wake request ce2 stays low indefinitely. A wake request that arrives during the setup or minimum-low interval is kept, and ce2 rises right after exactly PD_MIN_CYC low cycles.
- R8: On leaving deep sleep, ce2 and ce1_force_hi are both high, with bus_grant 0, for EXIT_HOLD_CYC + RECOVER_CYC cycles before bus_grant returns.
- R9: Whenever supply_ok is low at a clock edge, the outputs after that edge are ce2 = 0, bus_grant = 0 and ce1_force_hi = 1. This takes priority over a sleep entry in the same cycle. When supply returns, the full power-up runs again.
- R10: A sleep request outside the granted state and a wake request outside deep sleep have no effect.
- R11: bus_grant = 1 implies ce2 = 1, ce1_force_hi = 0 and busy = 0, and busy is the inverse of bus_grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Memory supply above its minimum |
| sleep_req | input | 1 | Host request to enter deep sleep (level or pulse) |
| wake_req | input | 1 | Host request to leave deep sleep (level or pulse) |
| ctrl_idle | input | 1 | Access controller has no cycle in progress |
| bus_grant | output | 1 | Access controller may run memory cycles |
| ce1_force_hi | output | 1 | Forces the primary chip enable high when 1 |
| ce2 | output | 1 | Power-control chip enable pin level |
| busy | output | 1 | Sequencer is powering up, sleeping or recovering |

## Verification
Two events can fall on the same edge. The first is a loss of supply in the very cycle where a pending sleep would be accepted with the controller idle. The second is a wake request landing in the last cycle of the minimum low time instead of being queued earlier. The bench creates the first by dropping supply_ok and raising sleep_req on the same negative edge. It then requires ce2 low, no grant and a restarted power-up, rather than a setup interval with ce2 still high. The second case and every other cycle are judged against a behavioural model run for both power-up variants, with the low and recovery run lengths measured at the pins.

// File: rtl/psram_pwr_pkg.sv
// Shared types for the pseudo-SRAM power sequencer.
// Holds the phase encoding and the pin level of the power-control enable
// in each phase; no state of its own.
package psram_pwr_pkg;

    typedef enum logic [3:0] {
        ST_OFF,       // supply not good, memory held in reset
        ST_PU_LO,     // default power-up: power-control enable low
        ST_PU_HI,     // alternate power-up: power-control enable high
        ST_REC,       // long recovery with primary enable forced high
        ST_READY,     // bus granted to the access controller
        ST_PD_SETUP,  // primary enable high before power-control enable falls
        ST_PD_LOW,    // minimum low time after deep-sleep entry
        ST_PD_SLEEP,  // deep sleep, waiting for a wake request
        ST_PD_EXIT    // primary enable held after power-control enable rises
    } pwr_state_e;

    // Level of the power-control enable pin while in a given phase.
    function automatic logic ce2_level(pwr_state_e s);
        return !(s == ST_OFF || s == ST_PU_LO || s == ST_PD_LOW || s == ST_PD_SLEEP);
    endfunction

endpackage

// File: rtl/psram_pwr_timer.sv
// Interval timer for the power sequencer.
// A load with length N (N >= 1) makes done rise N-1 cycles later, so a
// phase that leaves on done lasts exactly N cycles. Assumes len >= 1.
module psram_pwr_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Count down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len - CW'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/psram_pwr_req.sv
// Request catcher for the power sequencer.
// Remembers a sleep request only while the bus is granted and a wake
// request only during deep-sleep entry; outside its window each flag is
// cleared, so requests there are dropped.
module psram_pwr_req (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_win,
    input  logic wake_win,
    input  logic sleep_req,
    input  logic wake_req,
    output logic sleep_pend,
    output logic wake_pend
);

    // Hold each request while its acceptance window is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_pend <= 1'b0;
            wake_pend  <= 1'b0;
        end else begin
            sleep_pend <= sleep_win & (sleep_pend | sleep_req);
            wake_pend  <= wake_win  & (wake_pend  | wake_req);
        end
    end

endmodule

// File: rtl/psram_pwr_seq.sv
// Pseudo-SRAM power-up and deep-sleep sequencer (top).
// Owns the power-control chip enable, forces the primary enable high
// outside normal operation and grants the bus to the access controller.
// Assumes every *_CYC parameter is at least 1; counts are clock cycles.
module psram_pwr_seq
    import psram_pwr_pkg::*;
#(
    parameter int unsigned PU_HOLD_CYC   = 5000,
    parameter int unsigned RECOVER_CYC   = 35000,
    parameter int unsigned CE1_SETUP_CYC = 1,
    parameter int unsigned PD_MIN_CYC    = 7,
    parameter int unsigned EXIT_HOLD_CYC = 1,
    parameter bit          ALT_POWERUP   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic ctrl_idle,
    output logic bus_grant,
    output logic ce1_force_hi,
    output logic ce2,
    output logic busy
);

    localparam int unsigned MAX_A = (PU_HOLD_CYC > RECOVER_CYC) ? PU_HOLD_CYC : RECOVER_CYC;
    localparam int unsigned MAX_B = (CE1_SETUP_CYC > PD_MIN_CYC) ? CE1_SETUP_CYC : PD_MIN_CYC;
    localparam int unsigned MAX_C = (MAX_B > EXIT_HOLD_CYC) ? MAX_B : EXIT_HOLD_CYC;
    localparam int unsigned MAX_D = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int          CW    = $clog2(MAX_D + 1);

    pwr_state_e    st_q, nxt;
    logic          boot_q;
    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_len;
    logic          sleep_pend, wake_pend;
    logic          wake_seen;

    // Length of the timed interval that starts when a phase is entered.
    function automatic logic [CW-1:0] hold_of(pwr_state_e s);
        case (s)
            ST_PU_LO, ST_PU_HI: return CW'(PU_HOLD_CYC);
            ST_REC:             return CW'(RECOVER_CYC);
            ST_PD_SETUP:        return CW'(CE1_SETUP_CYC);
            ST_PD_LOW:          return CW'(PD_MIN_CYC);
            ST_PD_EXIT:         return CW'(EXIT_HOLD_CYC);
            default:            return CW'(1);
        endcase
    endfunction

    psram_pwr_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .done  (tmr_done)
    );

    psram_pwr_req u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_win  (st_q == ST_READY),
        .wake_win   (st_q == ST_PD_SETUP || st_q == ST_PD_LOW),
        .sleep_req  (sleep_req),
        .wake_req   (wake_req),
        .sleep_pend (sleep_pend),
        .wake_pend  (wake_pend)
    );

    assign wake_seen = wake_req | wake_pend | boot_q;

    // Next phase: supply loss first, then timer expiry and host requests.
    always_comb begin
        nxt = st_q;
        if (!supply_ok) begin
            nxt = ST_OFF;
        end else begin
            case (st_q)
                ST_OFF:      nxt = ALT_POWERUP ? ST_PU_HI : ST_PU_LO;
                ST_PU_LO:    if (tmr_done) nxt = ST_REC;
                ST_PU_HI:    if (tmr_done) nxt = ST_PD_SETUP;
                ST_REC:      if (tmr_done) nxt = ST_READY;
                ST_READY:    if ((sleep_req | sleep_pend) & ctrl_idle) nxt = ST_PD_SETUP;
                ST_PD_SETUP: if (tmr_done) nxt = ST_PD_LOW;
                ST_PD_LOW:   if (tmr_done) nxt = wake_seen ? ST_PD_EXIT : ST_PD_SLEEP;
                ST_PD_SLEEP: if (wake_req) nxt = ST_PD_EXIT;
                ST_PD_EXIT:  if (tmr_done) nxt = ST_REC;
                default:     nxt = ST_OFF;
            endcase
        end
    end

    assign tmr_load = (nxt != st_q);
    assign tmr_len  = hold_of(nxt);

    // Phase register and the power-up-through-sleep marker of the alternate path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            boot_q <= 1'b0;
        end else begin
            st_q <= nxt;
            if (st_q == ST_OFF)
                boot_q <= ALT_POWERUP;
            else if (nxt == ST_PD_EXIT)
                boot_q <= 1'b0;
        end
    end

    // Registered pin levels, decoded from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce2          <= 1'b0;
            ce1_force_hi <= 1'b1;
            bus_grant    <= 1'b0;
            busy         <= 1'b1;
        end else begin
            ce2          <= ce2_level(nxt);
            ce1_force_hi <= (nxt != ST_READY);
            bus_grant    <= (nxt == ST_READY);
            busy         <= (nxt != ST_READY);
        end
    end

endmodule

// File: rtl/psram_pwr_seq_chk.sv
// Property checker for the power sequencer, bound to every instance.
// Watches only the pins; run lengths are measured with saturating counters.
module psram_pwr_seq_chk #(
    parameter int unsigned RECOVER_CYC   = 35000,
    parameter int unsigned CE1_SETUP_CYC = 1,
    parameter int unsigned PD_MIN_CYC    = 7
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic ctrl_idle,
    input logic bus_grant,
    input logic ce1_force_hi,
    input logic ce2,
    input logic busy
);

    logic [31:0] lo_cnt, hi_cnt, c1_cnt;
    logic        ce2_d, armed;

    // Run lengths of ce2 low, ce2 high and forced primary enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
            c1_cnt <= '0;
            ce2_d  <= 1'b0;
            armed  <= 1'b0;
        end else begin
            lo_cnt <= ce2 ? 32'd0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 32'd1);
            hi_cnt <= !ce2 ? 32'd0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 32'd1);
            c1_cnt <= !ce1_force_hi ? 32'd0 : ((c1_cnt == '1) ? c1_cnt : c1_cnt + 32'd1);
            ce2_d  <= ce2;
            if (!supply_ok || ce2)
                armed <= 1'b0;
            else if (ce2_d)
                armed <= 1'b1;
        end
    end

    a_r5_setup_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ce2) && $past(supply_ok)) |-> (ce1_force_hi && c1_cnt >= CE1_SETUP_CYC));

    a_r6_low_minimum: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ce2) && armed) |-> (lo_cnt >= PD_MIN_CYC));

    a_r8_recovery_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant) |-> (hi_cnt >= RECOVER_CYC));

    a_r4_entry_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_grant) && $past(supply_ok)) |-> $past(ctrl_idle));

    a_r9_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!bus_grant && !ce2 && ce1_force_hi));

    a_r11_grant_levels: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> (ce2 && !ce1_force_hi && !busy));

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
    .RECOVER_CYC   (RECOVER_CYC),
    .CE1_SETUP_CYC (CE1_SETUP_CYC),
    .PD_MIN_CYC    (PD_MIN_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .ctrl_idle    (ctrl_idle),
    .bus_grant    (bus_grant),
    .ce1_force_hi (ce1_force_hi),
    .ce2          (ce2),
    .busy         (busy)
);

// File: tb/psram_pwr_seq_bench.sv
// Bench: both power-up variants side by side, a behavioural model per
// variant compared every cycle, and pin-level run-length checks.
module psram_pwr_seq_bench;

    localparam int CLK_NS = 10;
    localparam int PU     = 12;
    localparam int REC    = 20;
    localparam int SET    = 2;
    localparam int PDMIN  = 5;
    localparam int EXH    = 3;

    localparam int P_OFF = 0, P_PULO = 1, P_PUHI = 2, P_REC = 3, P_RDY = 4,
                   P_SET = 5, P_LOW = 6, P_SLP = 7, P_EXIT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, supply_ok = 1'b0, sleep_req = 1'b0, wake_req = 1'b0, ctrl_idle = 1'b0;
    logic [1:0] grant, ce1f, ce2, busy;

    int checks = 0;
    int errors = 0;

    int ph [2];
    int left [2];
    bit sq [2];
    bit wq [2];
    bit boot [2];
    int lo_run [2];
    int last_lo [2];
    int hb_run [2];
    int last_hb [2];

    always #(CLK_NS / 2) clk = ~clk;

    psram_pwr_seq #(.PU_HOLD_CYC(PU), .RECOVER_CYC(REC), .CE1_SETUP_CYC(SET),
                    .PD_MIN_CYC(PDMIN), .EXIT_HOLD_CYC(EXH), .ALT_POWERUP(1'b0)) u_psram_pwr_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sleep_req(sleep_req),
        .wake_req(wake_req), .ctrl_idle(ctrl_idle), .bus_grant(grant[0]),
        .ce1_force_hi(ce1f[0]), .ce2(ce2[0]), .busy(busy[0]));

    psram_pwr_seq #(.PU_HOLD_CYC(PU), .RECOVER_CYC(REC), .CE1_SETUP_CYC(SET),
                    .PD_MIN_CYC(PDMIN), .EXIT_HOLD_CYC(EXH), .ALT_POWERUP(1'b1)) u_psram_pwr_seq_alt (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sleep_req(sleep_req),
        .wake_req(wake_req), .ctrl_idle(ctrl_idle), .bus_grant(grant[1]),
        .ce1_force_hi(ce1f[1]), .ce2(ce2[1]), .busy(busy[1]));

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string tag_of(int p);
        case (p)
            P_OFF:          return "R1";
            P_PULO, P_REC:  return "R2";
            P_PUHI:         return "R3";
            P_SET:          return "R5";
            P_LOW:          return "R6";
            P_SLP:          return "R7";
            P_EXIT:         return "R8";
            default:        return "R11";
        endcase
    endfunction

    // One clock of the reference behaviour for variant k (k=1: alternate power-up).
    task automatic model_step(int k);
        bit nsq, nwq;
        nsq = (ph[k] == P_RDY) && (sq[k] || sleep_req);
        nwq = (ph[k] == P_SET || ph[k] == P_LOW) && (wq[k] || wake_req);
        if (!rst_n) begin
            ph[k] = P_OFF; left[k] = 0; boot[k] = 0; nsq = 0; nwq = 0;
        end else if (!supply_ok) begin
            ph[k] = P_OFF;
        end else begin
            case (ph[k])
                P_OFF: begin ph[k] = (k == 1) ? P_PUHI : P_PULO; left[k] = PU; boot[k] = (k == 1); end
                P_PULO: if (left[k] > 1) left[k]--; else begin ph[k] = P_REC; left[k] = REC; end
                P_PUHI: if (left[k] > 1) left[k]--; else begin ph[k] = P_SET; left[k] = SET; end
                P_REC:  if (left[k] > 1) left[k]--; else ph[k] = P_RDY;
                P_RDY:  if ((sleep_req || sq[k]) && ctrl_idle) begin ph[k] = P_SET; left[k] = SET; end
                P_SET:  if (left[k] > 1) left[k]--; else begin ph[k] = P_LOW; left[k] = PDMIN; end
                P_LOW:  if (left[k] > 1) left[k]--;
                        else if (boot[k] || wake_req || wq[k]) begin ph[k] = P_EXIT; left[k] = EXH; boot[k] = 0; end
                        else ph[k] = P_SLP;
                P_SLP:  if (wake_req) begin ph[k] = P_EXIT; left[k] = EXH; end
                default: if (left[k] > 1) left[k]--; else begin ph[k] = P_REC; left[k] = REC; end
            endcase
        end
        sq[k] = nsq;
        wq[k] = nwq;
    endtask

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) model_step(k);
    end

    // Compare every cycle a quarter period after the edge, and track run lengths.
    always begin
        @(posedge clk);
        #(CLK_NS / 4);
        for (int k = 0; k < 2; k++) begin
            bit e_ce2;
            e_ce2 = !(ph[k] == P_OFF || ph[k] == P_PULO || ph[k] == P_LOW || ph[k] == P_SLP);
            chk(tag_of(ph[k]), $sformatf("ce2[%0d]", k), int'(ce2[k]), int'(e_ce2));
            chk(tag_of(ph[k]), $sformatf("bus_grant[%0d]", k), int'(grant[k]), int'(ph[k] == P_RDY));
            chk(tag_of(ph[k]), $sformatf("ce1_force_hi[%0d]", k), int'(ce1f[k]), int'(ph[k] != P_RDY));
            chk("R11", $sformatf("busy[%0d]", k), int'(busy[k]), int'(ph[k] != P_RDY));
            if (!ce2[k]) lo_run[k]++;
            else begin
                if (lo_run[k] > 0) last_lo[k] = lo_run[k];
                lo_run[k] = 0;
            end
            if (ce2[k] && !grant[k]) hb_run[k]++;
            else if (grant[k]) begin
                if (hb_run[k] > 0) last_hb[k] = hb_run[k];
                hb_run[k] = 0;
            end else hb_run[k] = 0;
        end
    end

    initial begin
        #(CLK_NS * 100000);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(4);
        for (int k = 0; k < 2; k++) begin
            chk("R1", "reset ce2", int'(ce2[k]), 0);
            chk("R1", "reset grant", int'(grant[k]), 0);
            chk("R1", "reset ce1_force_hi", int'(ce1f[k]), 1);
            chk("R1", "reset busy", int'(busy[k]), 1);
        end
        rst_n = 1'b1;
        tick(2);
        chk("R1", "supply low keeps grant off", int'(grant[0]), 0);

        // Power-up, with a sleep request thrown in while still powering up.
        supply_ok = 1'b1;
        tick(3);
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
        tick(60);
        ctrl_idle = 1'b1;
        tick(10);
        chk("R10", "sleep during power-up dropped, grant", int'(grant[0]), 1);
        chk("R10", "sleep during power-up dropped, grant alt", int'(grant[1]), 1);
        chk("R2", "recovery run before grant", last_hb[0], REC);
        chk("R3", "exit plus recovery run alt", last_hb[1], EXH + REC);
        chk("R3", "boot low run alt", last_lo[1], PDMIN);

        // Wake request while granted has no effect.
        wake_req = 1'b1; tick(1); wake_req = 1'b0;
        tick(3);
        chk("R10", "wake while granted ignored, ce2", int'(ce2[0]), 1);
        chk("R10", "wake while granted ignored, grant", int'(grant[0]), 1);

        // Sleep held off while the access controller is busy.
        ctrl_idle = 1'b0;
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
        tick(6);
        chk("R4", "sleep held while busy, grant", int'(grant[0]), 1);
        ctrl_idle = 1'b1;
        tick(2);
        chk("R4", "grant withdrawn after idle", int'(grant[0]), 0);
        chk("R5", "primary enable forced in setup", int'(ce1f[0]), 1);

        // Deep sleep with no wake request, then wake.
        tick(25);
        chk("R7", "stays asleep without wake", int'(ce2[0]), 0);
        chk("R7", "stays asleep without wake alt", int'(ce2[1]), 0);
        wake_req = 1'b1; tick(1); wake_req = 1'b0;
        tick(40);
        chk("R8", "grant back after wake", int'(grant[0]), 1);
        chk("R8", "exit plus recovery run", last_hb[0], EXH + REC);
        chk("R6", "low run at least minimum", int'(last_lo[0] >= PDMIN), 1);

        // Wake queued during the setup interval.
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
        wake_req = 1'b1;  tick(1); wake_req = 1'b0;
        tick(40);
        chk("R7", "queued wake gives minimum low run", last_lo[0], PDMIN);
        chk("R7", "queued wake gives minimum low run alt", last_lo[1], PDMIN);
        chk("R8", "grant back after queued wake", int'(grant[0]), 1);

        // Supply loss in the same cycle as an accepted sleep entry.
        sleep_req = 1'b1; supply_ok = 1'b0;
        tick(1);
        sleep_req = 1'b0;
        for (int k = 0; k < 2; k++) begin
            chk("R9", "supply loss beats sleep, ce2", int'(ce2[k]), 0);
            chk("R9", "supply loss beats sleep, grant", int'(grant[k]), 0);
            chk("R9", "supply loss beats sleep, ce1_force_hi", int'(ce1f[k]), 1);
        end
        tick(3);
        supply_ok = 1'b1;
        tick(60);
        chk("R9", "power-up reruns, grant", int'(grant[0]), 1);
        chk("R9", "power-up reruns, grant alt", int'(grant[1]), 1);
        chk("R2", "recovery run after restart", last_hb[0], REC);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule